// File: doc/BRIEF.md
# Key-Locked Indexed Extension Register Bank

This block is a CPU-facing bank of display-controller control registers. The CPU reaches it through one index port and one data port. A write with `idx_wr` selects the register index. A write with `data_wr` stores a byte at the selected index. `rdata` always shows the contents of the selected register.

The bank has three groups of registers:
- **Standard block:** indices 00h–18h, always accessible.
- **Key slots:** indices 38h and 39h, always accessible.
- **Extended set:** nine registers that can be reached only while both key slots hold their unlock values.

Each extended register has a power-on default. Reserved bits are forced to zero on every write.

The bank does not expose raw register bytes to the rest of the chip. It exports decoded control fields instead: the 20-bit display start address, the CPU base address, the logical line width, the linear window size/position/enable, the read-ahead cache enable and prefetch depth, and the write-posting enable. Several of these fields are built from bits spread over more than one register, and one field can override another.

Top module: `crx_regbank`

## Requirements
- R1: After reset, indices 31h, 35h, 43h, 51h, 54h and 58h hold 00h, index 40h holds A4h, and the window position pair holds 00h at 59h and 0Ah at 5Ah. All standard registers and both key slots hold 00h, so the bank starts locked.
- R2: The extended set is unlocked exactly while index 38h holds 48h and index 39h holds A0h. Writes to 38h and 39h are always accepted and read back unchanged.
- R3: While locked, a data write to an extended index leaves the register unchanged, and a read of an extended index returns 00h.
- R4: Indices 00h–18h are always writable and read back what was written. Any index outside the standard block, the key slots and the extended set reads 00h and ignores writes.
- R5: Reserved bits read back zero. The writable masks are: 31h:39h, 35h:0Fh, 40h:FFh, 43h:FFh, 51h:3Fh, 54h:07h, 58h:17h, 59h:03h, 5Ah:FFh.
- R6: A write to 54h stores its bits 2–0 rounded down to the nearest of 0, 1, 3, 7. So 2 stores 1, values 4–6 store 3, and 7 stores 7. `prefetch` shows the stored value.
- R7: `disp_start` = {51h[1:0], 31h[5:4], 0Ch, 0Dh}, a 20-bit word address.
- R8: `cpu_base` = {51h[3:2], 35h[3:0]} (address bits 19–14). `cpu_base_en` = 31h[0]. `enh_map` = 31h[3].
- R9: `line_width[7:0]` = 13h and `line_width[9:8]` = 51h[5:4]. When 51h[5:4] is zero, `line_width[8]` = 43h[2]. Otherwise 43h[2] is ignored.
- R10: `law_size` = 58h[1:0], `rac_en` = 58h[2] and `law_en` = 58h[4]. `law_base` = {59h[1:0], 5Ah} with its low 0, 4, 5 or 6 bits cleared for sizes 0, 1, 2, 3 respectively.
- R11: `write_post` = 40h[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idx_wr | input | 1 | Load `wdata` into the index register |
| data_wr | input | 1 | Write `wdata` to the selected register |
| wdata | input | 8 | Write byte for index or data |
| rdata | output | 8 | Contents of the selected register |
| disp_start | output | 20 | Display start word address |
| cpu_base | output | 6 | CPU base address bits 19–14 |
| cpu_base_en | output | 1 | CPU base offset enable |
| enh_map | output | 1 | Enhanced memory mapping select |
| line_width | output | 10 | Logical line width |
| law_size | output | 2 | Linear window size code |
| law_base | output | 10 | Linear window base, address bits 25–16 |
| law_en | output | 1 | Linear addressing enable |
| rac_en | output | 1 | Read-ahead cache enable |
| prefetch | output | 3 | Read-ahead extra prefetch depth |
| write_post | output | 1 | Write-posting FIFO enable |

## Verification
On every cycle, the assertions check that:
- a locked read of an extended index returns zero;
- a locked write leaves the decoded fields unchanged;
- the prefetch depth stays legal;
- the window base is aligned for the 1 MB size;
- unlocking only follows a key-slot write.

Only the bench scenarios can show:
- the exact bit assembly of the start address, base address and line width;
- the width override;
- the per-size window alignment;
- the reset defaults;
- that a partially correct key pair keeps the bank locked.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int REG_W  = 8;
  localparam int EXT_N  = 9;

  localparam logic [REG_W-1:0] KEY_A_IDX = 8'h38;
  localparam logic [REG_W-1:0] KEY_B_IDX = 8'h39;
  localparam logic [REG_W-1:0] KEY_A_VAL = 8'h48;
  localparam logic [REG_W-1:0] KEY_B_VAL = 8'hA0;

  // slot numbers of the extended set
  localparam int S_MEM  = 0;  // 31h
  localparam int S_BASE = 1;  // 35h
  localparam int S_MCTL = 2;  // 40h
  localparam int S_EMOD = 3;  // 43h
  localparam int S_SYS2 = 4;  // 51h
  localparam int S_PF   = 5;  // 54h
  localparam int S_LAW  = 6;  // 58h
  localparam int S_POSH = 7;  // 59h
  localparam int S_POSL = 8;  // 5Ah

  localparam logic [REG_W-1:0] EXT_IDX [EXT_N] =
    '{8'h31, 8'h35, 8'h40, 8'h43, 8'h51, 8'h54, 8'h58, 8'h59, 8'h5A};
  localparam logic [REG_W-1:0] EXT_RST [EXT_N] =
    '{8'h00, 8'h00, 8'hA4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0A};
  localparam logic [REG_W-1:0] EXT_MASK [EXT_N] =
    '{8'h39, 8'h0F, 8'hFF, 8'hFF, 8'h3F, 8'h07, 8'h17, 8'h03, 8'hFF};

  function automatic logic is_ext(input logic [REG_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < EXT_N; k++)
      if (idx == EXT_IDX[k]) hit = 1'b1;
    return hit;
  endfunction

  // round a prefetch request down to 0, 1, 3 or 7
  function automatic logic [2:0] round_pf(input logic [2:0] v);
    if (v == 3'd0)      return 3'd0;
    else if (v < 3'd3)  return 3'd1;
    else if (v < 3'd7)  return 3'd3;
    else                return 3'd7;
  endfunction
endpackage

// File: rtl/crx_key_gate.sv
module crx_key_gate
  import crx_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic          unlocked,
  output logic          key_hit,
  output logic [DW-1:0] key_rdata
);
  logic [DW-1:0] key_a_q, key_b_q, key_a_d, key_b_d;
  logic          en_a, en_b;

  always_comb begin
    en_a    = wr_en && (idx == KEY_A_IDX);
    en_b    = wr_en && (idx == KEY_B_IDX);
    key_a_d = wdata;
    key_b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a_q <= '0;
      key_b_q <= '0;
    end else begin
      if (en_a) key_a_q <= key_a_d;
      if (en_b) key_b_q <= key_b_d;
    end
  end

  always_comb begin
    unlocked  = (key_a_q == KEY_A_VAL) && (key_b_q == KEY_B_VAL);
    key_hit   = (idx == KEY_A_IDX) || (idx == KEY_B_IDX);
    key_rdata = (idx == KEY_A_IDX) ? key_a_q :
                (idx == KEY_B_IDX) ? key_b_q : '0;
  end
endmodule

// File: rtl/crx_std_bank.sv
module crx_std_bank
  import crx_pkg::*;
#(
  parameter int DW      = REG_W,
  parameter int NUM_STD = 25
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              idx,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_STD-1:0][DW-1:0] regs,
  output logic                       std_hit,
  output logic [DW-1:0]              std_rdata
);
  for (genvar g = 0; g < NUM_STD; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    always_comb en = wr_en && (idx == DW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs[g] = q;
  end

  always_comb begin
    std_hit   = (idx < DW'(NUM_STD));
    std_rdata = '0;
    for (int k = 0; k < NUM_STD; k++)
      if (idx == DW'(k)) std_rdata = regs[k];
  end
endmodule

// File: rtl/crx_ext_bank.sv
module crx_ext_bank
  import crx_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     unlocked,
  input  logic [DW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  output logic [EXT_N-1:0][DW-1:0] regs,
  output logic                     ext_hit,
  output logic [DW-1:0]            ext_rdata
);
  for (genvar g = 0; g < EXT_N; g++) begin : g_slot
    logic          en;
    logic [DW-1:0] d, q;
    always_comb begin
      en = wr_en && unlocked && (idx == EXT_IDX[g]);
      if (g == S_PF) d = DW'(round_pf(wdata[2:0]));
      else           d = wdata & EXT_MASK[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= EXT_RST[g];
      else if (en) q <= d;
    end
    assign regs[g] = q;
  end

  always_comb begin
    ext_hit   = 1'b0;
    ext_rdata = '0;
    for (int k = 0; k < EXT_N; k++)
      if (idx == EXT_IDX[k]) begin
        ext_hit = 1'b1;
        if (unlocked) ext_rdata = regs[k];
      end
  end
endmodule

// File: rtl/crx_field_decode.sv
module crx_field_decode #(
  parameter int POS_W = 10
) (
  input  logic [7:0]       start_lo,
  input  logic [7:0]       start_mid,
  input  logic [7:0]       offset_lo,
  input  logic [5:0]       mem_cfg,
  input  logic [3:0]       base_lo,
  input  logic             post_bit,
  input  logic             width_b8,
  input  logic [5:0]       sys2,
  input  logic [2:0]       pf_q,
  input  logic [4:0]       law_ctl,
  input  logic [POS_W-1:0] law_pos,
  output logic [19:0]      disp_start,
  output logic [5:0]       cpu_base,
  output logic             cpu_base_en,
  output logic             enh_map,
  output logic [9:0]       line_width,
  output logic [1:0]       law_size,
  output logic [POS_W-1:0] law_base,
  output logic             law_en,
  output logic             rac_en,
  output logic [2:0]       prefetch,
  output logic             write_post
);
  logic [POS_W-1:0] align_mask;
  int               clr;

  always_comb begin
    disp_start  = {sys2[1:0], mem_cfg[5:4], start_mid, start_lo};
    cpu_base    = {sys2[3:2], base_lo};
    cpu_base_en = mem_cfg[0];
    enh_map     = mem_cfg[3];
    line_width[7:0] = offset_lo;
    if (sys2[5:4] != 2'b00) line_width[9:8] = sys2[5:4];
    else                    line_width[9:8] = {1'b0, width_b8};
    law_size    = law_ctl[1:0];
    rac_en      = law_ctl[2];
    law_en      = law_ctl[4];
    clr         = (law_size == 2'd0) ? 0 : int'(law_size) + 3;
    align_mask  = ~((POS_W'(1) << clr) - POS_W'(1));
    law_base    = law_pos & align_mask;
    prefetch    = pf_q;
    write_post  = post_bit;
  end
endmodule

// File: rtl/crx_regbank.sv
module crx_regbank
  import crx_pkg::*;
#(
  parameter int NUM_STD = 25,
  parameter int POS_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [19:0]      disp_start,
  output logic [5:0]       cpu_base,
  output logic             cpu_base_en,
  output logic             enh_map,
  output logic [9:0]       line_width,
  output logic [1:0]       law_size,
  output logic [POS_W-1:0] law_base,
  output logic             law_en,
  output logic             rac_en,
  output logic [2:0]       prefetch,
  output logic             write_post
);
  localparam int DW = REG_W;

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [DW-1:0] idx_q, idx_d;
  logic          unlocked, key_hit, std_hit, ext_hit;
  logic [DW-1:0] key_rdata, std_rdata, ext_rdata;
  logic [NUM_STD-1:0][DW-1:0] std_q;
  logic [EXT_N-1:0][DW-1:0]   ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb idx_d = idx_wr ? wdata : idx_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) idx_q <= '0;
    else             idx_q <= idx_d;
  end

  crx_key_gate #(.DW(DW)) u_key (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(data_wr), .idx(idx_q),
    .wdata(wdata), .unlocked(unlocked), .key_hit(key_hit),
    .key_rdata(key_rdata)
  );

  crx_std_bank #(.DW(DW), .NUM_STD(NUM_STD)) u_std (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(data_wr), .idx(idx_q),
    .wdata(wdata), .regs(std_q), .std_hit(std_hit), .std_rdata(std_rdata)
  );

  crx_ext_bank #(.DW(DW)) u_ext (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(data_wr), .unlocked(unlocked),
    .idx(idx_q), .wdata(wdata), .regs(ext_q), .ext_hit(ext_hit),
    .ext_rdata(ext_rdata)
  );

  always_comb begin
    if (key_hit)      rdata = key_rdata;
    else if (ext_hit) rdata = ext_rdata;
    else if (std_hit) rdata = std_rdata;
    else              rdata = '0;
  end

  crx_field_decode #(.POS_W(POS_W)) u_dec (
    .start_lo   (std_q[8'h0D]),
    .start_mid  (std_q[8'h0C]),
    .offset_lo  (std_q[8'h13]),
    .mem_cfg    (ext_q[S_MEM][5:0]),
    .base_lo    (ext_q[S_BASE][3:0]),
    .post_bit   (ext_q[S_MCTL][3]),
    .width_b8   (ext_q[S_EMOD][2]),
    .sys2       (ext_q[S_SYS2][5:0]),
    .pf_q       (ext_q[S_PF][2:0]),
    .law_ctl    (ext_q[S_LAW][4:0]),
    .law_pos    (POS_W'({ext_q[S_POSH][1:0], ext_q[S_POSL]})),
    .disp_start (disp_start),
    .cpu_base   (cpu_base),
    .cpu_base_en(cpu_base_en),
    .enh_map    (enh_map),
    .line_width (line_width),
    .law_size   (law_size),
    .law_base   (law_base),
    .law_en     (law_en),
    .rac_en     (rac_en),
    .prefetch   (prefetch),
    .write_post (write_post)
  );
endmodule

// File: rtl/crx_regbank_chk.sv
module crx_regbank_chk
  import crx_pkg::*;
#(
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       idx,
  input logic             unlocked,
  input logic             data_wr,
  input logic [7:0]       rdata,
  input logic [19:0]      disp_start,
  input logic [POS_W-1:0] law_base,
  input logic [1:0]       law_size,
  input logic [2:0]       prefetch,
  input logic             write_post
);
  // R3: locked extended reads are zero
  a_r3_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && is_ext(idx)) |-> (rdata == 8'h00));

  // R3: locked extended writes change no decoded field
  a_r3_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && data_wr && is_ext(idx)) |=>
      ($stable(prefetch) && $stable(law_base) && $stable(write_post)
       && $stable(disp_start[19:16])));

  // R6: prefetch depth is always legal
  a_r6_prefetch_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch == 3'd0 || prefetch == 3'd1 || prefetch == 3'd3 || prefetch == 3'd7));

  // R5: reserved bits of 54h read zero
  a_r5_pf_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 8'h54) |-> (rdata[7:3] == 5'd0));

  // R10: 1 MB window is 1 MB aligned
  a_r10_window_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (law_size == 2'd1) |-> (law_base[3:0] == 4'd0));

  // R2: unlocking follows a key-slot write
  a_r2_unlock_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(data_wr) &&
      ($past(idx) == KEY_A_IDX || $past(idx) == KEY_B_IDX)));
endmodule

bind crx_regbank crx_regbank_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .idx(idx_q), .unlocked(unlocked),
  .data_wr(data_wr), .rdata(rdata), .disp_start(disp_start),
  .law_base(law_base), .law_size(law_size), .prefetch(prefetch),
  .write_post(write_post)
);

// File: tb/crx_regbank_test.sv
module crx_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, idx_wr, data_wr;
  logic [7:0]  wdata, rdata;
  logic [19:0] disp_start;
  logic [5:0]  cpu_base;
  logic        cpu_base_en, enh_map, law_en, rac_en, write_post;
  logic [9:0]  line_width, law_base;
  logic [1:0]  law_size;
  logic [2:0]  prefetch;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  crx_regbank uut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(wdata), .rdata(rdata), .disp_start(disp_start),
    .cpu_base(cpu_base), .cpu_base_en(cpu_base_en), .enh_map(enh_map),
    .line_width(line_width), .law_size(law_size), .law_base(law_base),
    .law_en(law_en), .rac_en(rac_en), .prefetch(prefetch),
    .write_post(write_post)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_idx(input logic [7:0] i);
    idx_wr = 1'b1; wdata = i;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] i, input logic [7:0] v);
    put_idx(i);
    data_wr = 1'b1; wdata = v;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] i, output logic [7:0] v);
    put_idx(i);
    v = rdata;
  endtask

  task automatic unlock;
    wreg(8'h38, 8'h48); wreg(8'h39, 8'hA0);
  endtask

  task automatic lock;
    wreg(8'h38, 8'h00); wreg(8'h39, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ext_idx  [9] = '{8'h31,8'h35,8'h40,8'h43,8'h51,8'h54,8'h58,8'h59,8'h5A};
    logic [7:0] ext_rst  [9] = '{8'h00,8'h00,8'hA4,8'h00,8'h00,8'h00,8'h00,8'h00,8'h0A};
    logic [7:0] ext_mask [9] = '{8'h39,8'h0F,8'hFF,8'hFF,8'h3F,8'h07,8'h17,8'h03,8'hFF};
    int starts [5] = '{32'h00000, 32'hFFFFF, 32'h12345, 32'hA5C3E, 32'h40001};

    rst_n = 1'b0; idx_wr = 1'b0; data_wr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state at outputs and locked
    chk("R1 law_base", int'(law_base), 'h00A);
    chk("R1 write_post", int'(write_post), 0);
    chk("R1 prefetch", int'(prefetch), 0);
    chk("R1 disp_start", int'(disp_start), 0);
    rreg(8'h38, v); chk("R1 key38", int'(v), 0);
    rreg(8'h40, v); chk("R1/R3 locked read 40", int'(v), 0);
    for (int i = 0; i < 25; i++) begin
      rreg(8'(i), v); chk("R1 std reset", int'(v), 0);
    end
    unlock;
    for (int k = 0; k < 9; k++) begin
      rreg(ext_idx[k], v); chk("R1 ext reset", int'(v), int'(ext_rst[k]));
    end

    // R3 locked writes dropped
    lock;
    wreg(8'h58, 8'h11); wreg(8'h54, 8'h07); wreg(8'h40, 8'h08);
    chk("R3 law_en unchanged", int'(law_en), 0);
    chk("R3 prefetch unchanged", int'(prefetch), 0);
    chk("R3 write_post unchanged", int'(write_post), 0);
    rreg(8'h58, v); chk("R3 locked read 58", int'(v), 0);
    unlock;
    rreg(8'h58, v); chk("R3 58 kept", int'(v), 0);

    // R2 partial keys keep lock, keys read back
    lock;
    wreg(8'h38, 8'h48); wreg(8'h39, 8'hA1);
    rreg(8'h40, v); chk("R2 wrong key B", int'(v), 0);
    rreg(8'h39, v); chk("R2 key B readback", int'(v), 'hA1);
    wreg(8'h38, 8'h49); wreg(8'h39, 8'hA0);
    rreg(8'h40, v); chk("R2 wrong key A", int'(v), 0);
    rreg(8'h38, v); chk("R2 key A readback", int'(v), 'h49);
    wreg(8'h38, 8'h48);
    rreg(8'h40, v); chk("R2 unlocked", int'(v), 'hA4);

    // R4 standard sweep and unmapped indices
    for (int i = 0; i < 25; i++) wreg(8'(i), 8'((i * 37 + 5) & 255));
    for (int i = 0; i < 25; i++) begin
      rreg(8'(i), v); chk("R4 std readback", int'(v), (i * 37 + 5) & 255);
    end
    lock;
    wreg(8'h05, 8'h3C);
    rreg(8'h05, v); chk("R4 std while locked", int'(v), 'h3C);
    unlock;
    wreg(8'h20, 8'hFF); rreg(8'h20, v); chk("R4 unmapped 20", int'(v), 0);
    wreg(8'hFF, 8'h55); rreg(8'hFF, v); chk("R4 unmapped FF", int'(v), 0);

    // R5 reserved masks
    for (int k = 0; k < 9; k++) begin
      wreg(ext_idx[k], 8'hFF);
      rreg(ext_idx[k], v); chk("R5 mask", int'(v), int'(ext_mask[k]));
    end

    // R6 prefetch rounding, all codes
    for (int p = 0; p < 8; p++) begin
      int e;
      e = (p == 0) ? 0 : (p < 3) ? 1 : (p < 7) ? 3 : 7;
      wreg(8'h54, 8'(p | 8'hF8));
      rreg(8'h54, v); chk("R6 stored", int'(v), e);
      chk("R6 prefetch out", int'(prefetch), e);
    end

    // R7 display start assembly
    for (int s = 0; s < 5; s++) begin
      int a;
      a = starts[s];
      wreg(8'h0D, 8'(a & 255));
      wreg(8'h0C, 8'((a >> 8) & 255));
      wreg(8'h31, 8'(((a >> 16) & 3) << 4));
      wreg(8'h51, 8'((a >> 18) & 3));
      chk("R7 disp_start", int'(disp_start), a);
    end

    // R8 cpu base and flags
    for (int b = 0; b < 64; b += 21) begin
      wreg(8'h35, 8'(b & 15));
      wreg(8'h51, 8'(((b >> 4) & 3) << 2));
      chk("R8 cpu_base", int'(cpu_base), b);
    end
    wreg(8'h31, 8'h09);
    chk("R8 base_en", int'(cpu_base_en), 1);
    chk("R8 enh_map", int'(enh_map), 1);
    wreg(8'h31, 8'h08);
    chk("R8 base_en off", int'(cpu_base_en), 0);

    // R9 line width and override
    wreg(8'h13, 8'h80); wreg(8'h43, 8'h04); wreg(8'h51, 8'h00);
    chk("R9 bit8 from 43", int'(line_width), 'h180);
    wreg(8'h51, 8'h20);
    chk("R9 43 ignored", int'(line_width), 'h280);
    wreg(8'h51, 8'h30);
    chk("R9 ext bits", int'(line_width), 'h380);
    wreg(8'h43, 8'h00); wreg(8'h51, 8'h00);
    chk("R9 plain", int'(line_width), 'h080);

    // R10 window decode
    wreg(8'h59, 8'h03); wreg(8'h5A, 8'h3F);
    for (int sz = 0; sz < 4; sz++) begin
      int c;
      c = (sz == 0) ? 0 : sz + 3;
      wreg(8'h58, 8'(8'h14 | sz));
      chk("R10 law_size", int'(law_size), sz);
      chk("R10 law_base", int'(law_base), ('h33F >> c) << c);
    end
    chk("R10 law_en", int'(law_en), 1);
    chk("R10 rac_en", int'(rac_en), 1);
    wreg(8'h58, 8'h01);
    chk("R10 law_en off", int'(law_en), 0);

    // R11 write posting
    wreg(8'h40, 8'h08);
    chk("R11 write_post on", int'(write_post), 1);
    wreg(8'h40, 8'hA4);
    chk("R11 write_post off", int'(write_post), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule